// File: doc/BRIEF.md
# Status Word and Banked Stack Pointer Unit

This unit holds a processor's 16-bit status word together with three stack pointers: one for user code, one for interrupt handling and one for a master supervisor context. Only one of them is live at a time and is presented as address register 7. The supervisor bit (S, bit 13) and the master bit (M, bit 12) of the status word choose which one. The other two sit in shadow registers. When a status write moves S or M, the unit swaps pointers in a single clock edge. The outgoing live value goes to its shadow, and the incoming shadow becomes the live register.

Instruction logic reads and writes the live pointer through a dedicated port. Context-switch code can reach any of the three pointers by name through a second port, without first changing mode. A build-time variant selects a basic status layout or an extended one. The basic layout has no second trace bit and no master bit, so it never selects the master bank. Two 3-bit function-code registers, one for the source space and one for the destination space, complete the unit.

Top module: `sr_sp_unit`

## Requirements
- R1: After reset the status word reads 0x2700 (S=1, M=0, interrupt mask 7). `active_bank` reads 1 (interrupt). The live pointer, all named pointers and both function codes read 0.
- R2: A status write stores `sr_wdata & MASK`, where MASK is 0xF71F in the extended variant and 0xA71F in the basic variant. Bits cleared by MASK always read 0.
- R3: `active_bank` encodes the live bank as follows: 0 means user (S=0); 1 means interrupt (S=1, M=0); 2 means master (S=1, M=1). In the basic variant the master bank is never selected.
- R4: With no bank change, an A7 write makes `a7_rdata` equal the written value from the next cycle.
- R5: A named read with `bank_rsel` 0, 1 or 2 returns the live A7 when that bank is active and its shadow otherwise. Code 3 reads 0. The read is combinational.
- R6: A named write with `bank_sel` 0, 1 or 2 updates the live A7 when that bank is active and only its shadow otherwise. Code 3 changes nothing.
- R7: A status write that changes S or M saves the outgoing live A7 into the outgoing bank's shadow. It loads the incoming bank's shadow into A7. Both are visible the next cycle.
- R8: Pointer writes in the same cycle as a bank change resolve against the bank that was active before the edge, and only then are the pointers swapped. When an A7 write and a named write to the active bank coincide, the A7 write wins.
- R9: Each function-code register keeps only bits 2..0 of its written value.
- R10: A status write that leaves S and M unchanged causes no swap. Without a pointer write, A7 and every shadow hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 16 | Status word write data |
| sr_rdata | output | 16 | Current status word |
| active_bank | output | 2 | Live bank code (0 user, 1 interrupt, 2 master) |
| a7_we | input | 1 | Live A7 write enable |
| a7_wdata | input | PTR_W | Live A7 write data |
| a7_rdata | output | PTR_W | Live A7 value |
| bank_we | input | 1 | Named pointer write enable |
| bank_sel | input | 2 | Named pointer write select |
| bank_wdata | input | PTR_W | Named pointer write data |
| bank_rsel | input | 2 | Named pointer read select |
| bank_rdata | output | PTR_W | Named pointer read data |
| sfc_we | input | 1 | Source function code write enable |
| sfc_wdata | input | PTR_W | Source function code write data |
| sfc_rdata | output | 3 | Source function code |
| dfc_we | input | 1 | Destination function code write enable |
| dfc_wdata | input | PTR_W | Destination function code write data |
| dfc_rdata | output | 3 | Destination function code |

## Verification
Two events can land in the same cycle: a status write that switches banks, and a pointer write through either port. The bench drives every pairing of starting bank and target bank. For each pairing it applies all sixteen combinations of A7 write, named write and named select in that same cycle. After each edge it judges the status word, the bank code, the live A7 and all four named reads against a bench model. In that model the writes land on the pre-edge bank first and the swap follows.

// File: rtl/sr_sp_pkg.sv
`timescale 1ns/1ps
package sr_sp_pkg;

  typedef enum logic [1:0] {
    BANK_USR  = 2'd0,
    BANK_INT  = 2'd1,
    BANK_MST  = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  localparam int          SR_W     = 16;
  localparam int          BIT_S    = 13;
  localparam int          BIT_M    = 12;
  localparam int          NUM_BANK = 3;
  localparam logic [15:0] SR_RESET = 16'h2700;

  // Writable status bits for each layout variant.
  function automatic logic [15:0] status_mask(input bit ext);
    return ext ? 16'hF71F : 16'hA71F;
  endfunction

  // Bank selected by the supervisor and master bits.
  function automatic bank_e bank_of(input logic [15:0] sr);
    if (!sr[BIT_S])     return BANK_USR;
    else if (sr[BIT_M]) return BANK_MST;
    else                return BANK_INT;
  endfunction

endpackage

// File: rtl/sr_word.sv
`timescale 1ns/1ps
module sr_word
  import sr_sp_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] q,
  output bank_e       cur_bank,
  output bank_e       nxt_bank,
  output logic        swap
);
  localparam logic [15:0] MASK = status_mask(EXT);

  logic [15:0] q_r;
  logic [15:0] d;

  always_comb d = we ? (wdata & MASK) : q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= SR_RESET & MASK;
    else        q_r <= d;
  end

  assign q        = q_r;
  assign cur_bank = bank_of(q_r);
  assign nxt_bank = bank_of(d);
  assign swap     = (cur_bank != nxt_bank);
endmodule

// File: rtl/sp_bank_file.sv
`timescale 1ns/1ps
module sp_bank_file
  import sr_sp_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_e            cur_bank,
  input  bank_e            nxt_bank,
  input  logic             swap,
  input  logic             a7_we,
  input  logic [PTR_W-1:0] a7_wdata,
  input  logic             wr_en,
  input  bank_e            wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  bank_e            rd_sel,
  output logic [PTR_W-1:0] live,
  output logic [PTR_W-1:0] rd_data,
  output logic [PTR_W-1:0] incoming
);
  logic [PTR_W-1:0] live_q;
  logic [PTR_W-1:0] live_d;
  logic [PTR_W-1:0] shd_q   [NUM_BANK];
  logic [PTR_W-1:0] shd_pre [NUM_BANK];

  // Live value after this cycle's writes, before any swap.
  always_comb begin
    if (a7_we)                             live_d = a7_wdata;
    else if (wr_en && wr_sel == cur_bank)  live_d = wr_data;
    else                                   live_d = live_q;
  end

  for (genvar i = 0; i < NUM_BANK; i++) begin : g_shadow
    always_comb begin
      if (wr_en && wr_sel == bank_e'(i) && cur_bank != bank_e'(i))
        shd_pre[i] = wr_data;
      else
        shd_pre[i] = shd_q[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                              shd_q[i] <= '0;
      else if (swap && cur_bank == bank_e'(i)) shd_q[i] <= live_d;
      else                                     shd_q[i] <= shd_pre[i];
    end
  end

  always_comb begin
    case (nxt_bank)
      BANK_USR: incoming = shd_pre[0];
      BANK_INT: incoming = shd_pre[1];
      BANK_MST: incoming = shd_pre[2];
      default:  incoming = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    live_q <= '0;
    else if (swap) live_q <= incoming;
    else           live_q <= live_d;
  end

  always_comb begin
    if (rd_sel == BANK_NONE)     rd_data = '0;
    else if (rd_sel == cur_bank) rd_data = live_q;
    else begin
      case (rd_sel)
        BANK_USR: rd_data = shd_q[0];
        BANK_INT: rd_data = shd_q[1];
        default:  rd_data = shd_q[2];
      endcase
    end
  end

  assign live = live_q;
endmodule

// File: rtl/fc_reg.sv
`timescale 1ns/1ps
module fc_reg #(
  parameter int IN_W = 32,
  parameter int FC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IN_W-1:0] wdata,
  output logic [FC_W-1:0] q
);
  logic fc_unused_hi;
  assign fc_unused_hi = ^wdata[IN_W-1:FC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata[FC_W-1:0];
  end
endmodule

// File: rtl/sr_sp_unit.sv
`timescale 1ns/1ps
module sr_sp_unit
  import sr_sp_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter bit EXT   = 1'b1,
  parameter int FC_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_we,
  input  logic [15:0]      sr_wdata,
  output logic [15:0]      sr_rdata,
  output logic [1:0]       active_bank,
  input  logic             a7_we,
  input  logic [PTR_W-1:0] a7_wdata,
  output logic [PTR_W-1:0] a7_rdata,
  input  logic             bank_we,
  input  logic [1:0]       bank_sel,
  input  logic [PTR_W-1:0] bank_wdata,
  input  logic [1:0]       bank_rsel,
  output logic [PTR_W-1:0] bank_rdata,
  input  logic             sfc_we,
  input  logic [PTR_W-1:0] sfc_wdata,
  output logic [FC_W-1:0]  sfc_rdata,
  input  logic             dfc_we,
  input  logic [PTR_W-1:0] dfc_wdata,
  output logic [FC_W-1:0]  dfc_rdata
);
  localparam int NUM_FC = 2;

  // Named internal events, brought out for the checker.
  bank_e            cur_bank;
  bank_e            nxt_bank;
  logic             bank_swap;
  logic [PTR_W-1:0] incoming_shadow;

  sr_word #(.EXT(EXT)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (sr_we),
    .wdata    (sr_wdata),
    .q        (sr_rdata),
    .cur_bank (cur_bank),
    .nxt_bank (nxt_bank),
    .swap     (bank_swap)
  );

  sp_bank_file #(.PTR_W(PTR_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_bank (cur_bank),
    .nxt_bank (nxt_bank),
    .swap     (bank_swap),
    .a7_we    (a7_we),
    .a7_wdata (a7_wdata),
    .wr_en    (bank_we),
    .wr_sel   (bank_e'(bank_sel)),
    .wr_data  (bank_wdata),
    .rd_sel   (bank_e'(bank_rsel)),
    .live     (a7_rdata),
    .rd_data  (bank_rdata),
    .incoming (incoming_shadow)
  );

  assign active_bank = cur_bank;

  logic [NUM_FC-1:0]  fc_we;
  logic [PTR_W-1:0]   fc_wd [NUM_FC];
  logic [FC_W-1:0]    fc_q  [NUM_FC];

  assign fc_we    = {dfc_we, sfc_we};
  assign fc_wd[0] = sfc_wdata;
  assign fc_wd[1] = dfc_wdata;

  for (genvar k = 0; k < NUM_FC; k++) begin : g_fc
    fc_reg #(.IN_W(PTR_W), .FC_W(FC_W)) u_fc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fc_we[k]),
      .wdata (fc_wd[k]),
      .q     (fc_q[k])
    );
  end

  assign sfc_rdata = fc_q[0];
  assign dfc_rdata = fc_q[1];
endmodule

// File: rtl/sr_sp_unit_chk.sv
`timescale 1ns/1ps
module sr_sp_unit_chk
  import sr_sp_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter bit EXT   = 1'b1,
  parameter int FC_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sr_we,
  input logic [15:0]      sr_rdata,
  input logic [1:0]       active_bank,
  input logic             a7_we,
  input logic [PTR_W-1:0] a7_wdata,
  input logic [PTR_W-1:0] a7_rdata,
  input logic             bank_we,
  input logic             sfc_we,
  input logic [PTR_W-1:0] sfc_wdata,
  input logic [FC_W-1:0]  sfc_rdata,
  input logic             bank_swap,
  input logic [PTR_W-1:0] incoming_shadow
);
  localparam logic [15:0] MASK = status_mask(EXT);

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata & ~MASK) == 16'h0);

  p_user_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_rdata[BIT_S] |-> active_bank == 2'd0);

  p_sup_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rdata[BIT_S] |-> (active_bank == (sr_rdata[BIT_M] ? 2'd2 : 2'd1)));

  p_a7_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a7_we && !bank_swap) |=> a7_rdata == $past(a7_wdata));

  p_swap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |=> a7_rdata == $past(incoming_shadow));

  p_a7_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a7_we && !bank_we && !bank_swap) |=> $stable(a7_rdata));

  p_sr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> $stable(sr_rdata));

  p_fc_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sfc_we |=> sfc_rdata == $past(sfc_wdata[FC_W-1:0]));
endmodule

bind sr_sp_unit sr_sp_unit_chk #(.PTR_W(PTR_W), .EXT(EXT), .FC_W(FC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sr_we           (sr_we),
  .sr_rdata        (sr_rdata),
  .active_bank     (active_bank),
  .a7_we           (a7_we),
  .a7_wdata        (a7_wdata),
  .a7_rdata        (a7_rdata),
  .bank_we         (bank_we),
  .sfc_we          (sfc_we),
  .sfc_wdata       (sfc_wdata),
  .sfc_rdata       (sfc_rdata),
  .bank_swap       (bank_swap),
  .incoming_shadow (incoming_shadow)
);

// File: tb/tb_sr_sp_unit.sv
`timescale 1ns/1ps
module tb_sr_sp_unit;
  localparam int PTR_W = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sr_we;
  logic [15:0]      sr_wdata;
  logic [15:0]      sr_rdata, sr_rdata_b;
  logic [1:0]       active_bank, active_bank_b;
  logic             a7_we;
  logic [PTR_W-1:0] a7_wdata, a7_rdata, a7_rdata_b;
  logic             bank_we;
  logic [1:0]       bank_sel, bank_rsel;
  logic [PTR_W-1:0] bank_wdata, bank_rdata, bank_rdata_b;
  logic             sfc_we, dfc_we;
  logic [PTR_W-1:0] sfc_wdata, dfc_wdata;
  logic [2:0]       sfc_rdata, dfc_rdata, sfc_rdata_b, dfc_rdata_b;

  always #2 clk = ~clk;

  sr_sp_unit #(.PTR_W(PTR_W), .EXT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata), .active_bank(active_bank), .a7_we(a7_we),
    .a7_wdata(a7_wdata), .a7_rdata(a7_rdata), .bank_we(bank_we),
    .bank_sel(bank_sel), .bank_wdata(bank_wdata), .bank_rsel(bank_rsel),
    .bank_rdata(bank_rdata), .sfc_we(sfc_we), .sfc_wdata(sfc_wdata),
    .sfc_rdata(sfc_rdata), .dfc_we(dfc_we), .dfc_wdata(dfc_wdata),
    .dfc_rdata(dfc_rdata)
  );

  sr_sp_unit #(.PTR_W(PTR_W), .EXT(1'b0)) dut_basic (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata_b), .active_bank(active_bank_b), .a7_we(a7_we),
    .a7_wdata(a7_wdata), .a7_rdata(a7_rdata_b), .bank_we(bank_we),
    .bank_sel(bank_sel), .bank_wdata(bank_wdata), .bank_rsel(bank_rsel),
    .bank_rdata(bank_rdata_b), .sfc_we(sfc_we), .sfc_wdata(sfc_wdata),
    .sfc_rdata(sfc_rdata_b), .dfc_we(dfc_we), .dfc_wdata(dfc_wdata),
    .dfc_rdata(dfc_rdata_b)
  );

  int n_vec  = 0;
  int n_fail = 0;

  // Bench model: status words, live pointer, three shadows.
  logic [15:0]      m_sr, m_srb;
  logic [PTR_W-1:0] m_live;
  logic [PTR_W-1:0] m_shd [3];

  function automatic int bank_code(input logic [15:0] s);
    if (s[13] == 1'b0) return 0;
    return s[12] ? 2 : 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int cb;
    chk("R2 status word", {16'h0, sr_rdata}, {16'h0, m_sr});
    chk("R2 status word basic", {16'h0, sr_rdata_b}, {16'h0, m_srb});
    chk("R3 active bank", {30'h0, active_bank}, 32'(bank_code(m_sr)));
    chk("R3 active bank basic", {30'h0, active_bank_b}, 32'(bank_code(m_srb)));
    chk(tag, a7_rdata, m_live);
    cb = bank_code(m_sr);
    for (int k = 0; k < 4; k++) begin
      bank_rsel = 2'(k);
      #0.2;
      if (k == 3)       chk("R5 named read code 3", bank_rdata, '0);
      else if (k == cb) chk("R5 named read live", bank_rdata, m_live);
      else              chk({"R5 named read shadow ", tag}, bank_rdata, m_shd[k]);
    end
  endtask

  task automatic cyc(input bit swe, input logic [15:0] sd,
                     input bit awe, input logic [31:0] ad,
                     input bit bwe, input logic [1:0] bs, input logic [31:0] bd,
                     input string tag);
    int cb, nb;
    logic [31:0] lv;
    sr_we = swe; sr_wdata = sd;
    a7_we = awe; a7_wdata = ad;
    bank_we = bwe; bank_sel = bs; bank_wdata = bd;
    @(posedge clk);
    // Model: writes land on the pre-edge bank, then the swap.
    cb = bank_code(m_sr);
    lv = m_live;
    if (awe)                   lv = ad;
    else if (bwe && bs == cb)  lv = bd;
    if (bwe && bs != 2'd3 && bs != cb) m_shd[bs] = bd;
    if (swe) begin
      m_sr  = sd & 16'hF71F;
      m_srb = sd & 16'hA71F;
    end
    nb = bank_code(m_sr);
    if (nb != cb) begin
      m_shd[cb] = lv;
      lv = m_shd[nb];
    end
    m_live = lv;
    #1;
    sr_we = 1'b0; a7_we = 1'b0; bank_we = 1'b0;
    check_all(tag);
  endtask

  function automatic logic [15:0] sr_for(input int b);
    case (b)
      0:       return 16'h0015;
      1:       return 16'h2700;
      2:       return 16'h3300;
      default: return 16'h000A;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int vn;
    rst_n = 1'b0;
    sr_we = 0; sr_wdata = '0; a7_we = 0; a7_wdata = '0;
    bank_we = 0; bank_sel = '0; bank_wdata = '0; bank_rsel = '0;
    sfc_we = 0; sfc_wdata = '0; dfc_we = 0; dfc_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R1: reset state
    m_sr = 16'h2700; m_srb = 16'h2700; m_live = '0;
    for (int k = 0; k < 3; k++) m_shd[k] = '0;
    check_all("R1 reset A7");
    chk("R1 reset sfc", {29'h0, sfc_rdata}, 32'h0);
    chk("R1 reset dfc", {29'h0, dfc_rdata}, 32'h0);

    // Directed cases
    cyc(0, 16'h0, 1, 32'h1111_0000, 0, 2'd0, 32'h0, "R4 A7 write");
    cyc(0, 16'h0, 0, 32'h0, 1, 2'd0, 32'h2222_0000, "R6 named write inactive");
    cyc(0, 16'h0, 0, 32'h0, 1, 2'd1, 32'h3333_0000, "R6 named write active");
    cyc(0, 16'h0, 0, 32'h0, 1, 2'd3, 32'h4444_0000, "R6 named write code 3");
    cyc(1, 16'h0000, 0, 32'h0, 0, 2'd0, 32'h0, "R7 swap to user");
    cyc(1, 16'h0005, 0, 32'h0, 0, 2'd0, 32'h0, "R10 no swap");
    cyc(1, 16'hFFFF, 0, 32'h0, 0, 2'd0, 32'h0, "R7 swap to master, R2 mask");
    cyc(0, 16'h0, 0, 32'h0, 0, 2'd0, 32'h0, "R10 idle hold");

    // R9: function codes keep low 3 bits
    for (int v = 0; v < 16; v++) begin
      sfc_we = 1; dfc_we = 1;
      sfc_wdata = 32'hFFFF_FFF0 | 32'(v);
      dfc_wdata = 32'h1234_5670 | 32'(15 - v);
      @(posedge clk); #1;
      sfc_we = 0; dfc_we = 0;
      chk("R9 sfc low bits", {29'h0, sfc_rdata}, 32'(v & 7));
      chk("R9 dfc low bits", {29'h0, dfc_rdata}, 32'((15 - v) & 7));
    end

    // R8: every bank pairing against every same-cycle pointer-write pattern
    vn = 0;
    for (int from = 0; from < 4; from++) begin
      for (int to = 0; to < 4; to++) begin
        for (int p = 0; p < 16; p++) begin
          vn++;
          cyc(1, sr_for(from), 0, 32'h0, 0, 2'd0, 32'h0, "R7 setup");
          cyc(1, sr_for(to), p[0], 32'hA000_0000 | 32'(vn),
              p[1], 2'(p >> 2), 32'hB000_0000 | 32'(vn), "R8 collision");
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule